// File: doc/BRIEF.md
# SPI Register Bridge Slave

This block is an SPI slave that sits in a secondary FPGA. It gives a host device read and write access to an internal space of 32-bit registers. Each access is one frame: chip-select goes low, exactly two 32-bit words are shifted, and chip-select goes high again. The most significant bit of the first word selects the direction: 1 is a read and 0 is a write. The low `ADDR_W` bits of the first word are the word address. For a write, the second word is the data to store. For a read, the host shifts all ones as the second word, and the addressed register comes back on MISO during that same word.

On its internal side the block drives a plain register bus: an address, write data, a one-cycle write strobe and a one-cycle read strobe, plus a read-data input. The registers behind this bus are outside the block. The SPI pins are asynchronous to `clk` and pass through a two-flop synchronizer. SCLK is oversampled, so each SCLK high phase and each SCLK low phase must last at least four `clk` cycles. The bus has no back-pressure. The register side must present `bus_rdata` for `bus_addr` in the same `clk` cycle in which `bus_rd` is high, and must accept a write in the cycle in which `bus_wr` is high.

Top module: `spi_regbridge_slave`

## Requirements
- R1: After reset, and whenever chip-select is high, `bus_wr`, `bus_rd` and `spi_miso` are all 0.
- R2: A write frame gives exactly one `bus_wr` pulse, one `clk` cycle wide, after the 64th rising SCLK edge. In that cycle `bus_addr` equals bits [ADDR_W-1:0] of the first word and `bus_wdata` equals the second word.
- R3: A read frame gives exactly one `bus_rd` pulse, one `clk` cycle wide, after the 32nd rising SCLK edge. `bus_addr` equals bits [ADDR_W-1:0] of the first word.
- R4: In a read frame, the register value is driven on `spi_miso` MSB first during the second word. Bit 31 is valid at the 33rd rising SCLK edge and bit 0 at the 64th. MISO changes only on falling SCLK edges (SPI mode 0; MOSI is also MSB first and is sampled on rising edges).
- R5: Bit 31 of the first word is the direction flag (1 = read, 0 = write). A read frame never gives `bus_wr`, and a write frame never gives `bus_rd`.
- R6: If chip-select is released before the 64th rising edge, no write takes place. If it is released before the 32nd rising edge, no read takes place.
- R7: Releasing chip-select clears the bit counter and the frame state, so the next frame is decoded from its first bit.
- R8: Rising SCLK edges after the 64th in the same frame are ignored and give no further strobe.
- R9: Bits [30:ADDR_W] of the first word are ignored.
- R10: `spi_miso` is 0 during the first word of every frame and for the whole of a write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host (mode 0) |
| spi_csn | input | 1 | SPI chip-select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| bus_addr | output | ADDR_W | Register word address |
| bus_wdata | output | WORD_W | Register write data |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_rdata | input | WORD_W | Register read data, valid while `bus_rd` is high |

## Verification
A rising SCLK edge reaches the frame logic two `clk` cycles after it happens at the pin, because of the synchronizer. The strobe follows one `clk` cycle after that, so `bus_rd` and `bus_wr` appear about three to four `clk` cycles after the 32nd or 64th rising edge. A MISO bit appears at about the same delay after its falling edge. The bench holds each SCLK phase for six `clk` cycles, which is more than that delay. It therefore reads MISO just before it raises SCLK, as a host would. It counts strobes in a monitor at the falling `clk` edge, and it reads those counts only after chip-select has been high for several SCLK phases, so every strobe a frame can cause has already appeared. A sweep over all sixteen addresses of a 4-bit configuration checks each value against a register model kept in the bench.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int unsigned DEF_WORD_W = 32;
  localparam int unsigned DEF_ADDR_W = 10;
  localparam int unsigned DEF_SYNC_N = 2;

  // Progress through a two-word frame
  typedef enum logic [1:0] {
    FR_CMD  = 2'd0,
    FR_DATA = 2'd1,
    FR_DONE = 2'd2
  } frame_st_t;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic csn_s,
  output logic mosi_s
);
  localparam int unsigned LINES = 3;
  localparam logic [LINES-1:0] IDLE_VAL = 3'b100; // csn high, sclk low, mosi low

  logic [LINES-1:0] raw;
  logic [LINES-1:0] stage [SYNC_N];
  logic             sclk_d;

  assign raw = {csn_i, sclk_i, mosi_i};

  for (genvar g = 0; g < SYNC_N; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= IDLE_VAL;
        else        stage[g] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= IDLE_VAL;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= stage[SYNC_N-1][1];
  end

  assign csn_s     = stage[SYNC_N-1][2];
  assign mosi_s    = stage[SYNC_N-1][0];
  assign sclk_rise =  stage[SYNC_N-1][1] & ~sclk_d;
  assign sclk_fall = ~stage[SYNC_N-1][1] &  sclk_d;
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
  import spi_rb_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              csn_s,
  input  logic              mosi_s,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic              data_phase
);
  localparam int unsigned FRAME_BITS = 2 * WORD_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(FRAME_BITS - 1);

  frame_st_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] word_nxt;
  logic              is_rd;

  assign word_nxt   = {sh[WORD_W-2:0], mosi_s};
  assign data_phase = (st == FR_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FR_CMD;
      cnt       <= '0;
      sh        <= '0;
      is_rd     <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
    end else begin
      bus_wr <= 1'b0;
      bus_rd <= 1'b0;
      if (csn_s) begin
        st    <= FR_CMD;
        cnt   <= '0;
        sh    <= '0;
        is_rd <= 1'b0;
      end else if (sclk_rise && st != FR_DONE) begin
        sh  <= word_nxt;
        cnt <= cnt + 1'b1;
        if (st == FR_CMD && cnt == LAST_CMD) begin
          is_rd    <= word_nxt[WORD_W-1];
          bus_rd   <= word_nxt[WORD_W-1];
          bus_addr <= word_nxt[ADDR_W-1:0];
          st       <= FR_DATA;
        end else if (st == FR_DATA && cnt == LAST_DATA) begin
          st <= FR_DONE;
          if (!is_rd) begin
            bus_wr    <= 1'b1;
            bus_wdata <= word_nxt;
          end
        end
      end
    end
  end

  a_r2_single_wr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr);
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> $stable(bus_addr));
  a_r3_single_rd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> !bus_rd);
  a_r5_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  a_r6_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (!bus_wr && !bus_rd));
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_BITS));
endmodule

// File: rtl/spi_rb_tx.sv
module spi_rb_tx
  import spi_rb_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              sclk_fall,
  input  logic              data_phase,
  input  logic              load,
  input  logic [WORD_W-1:0] rdata,
  output logic              miso
);
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      miso <= 1'b0;
    end else if (csn_s) begin
      sr   <= '0;
      miso <= 1'b0;
    end else if (load) begin
      sr <= rdata;
    end else if (sclk_fall && data_phase) begin
      miso <= sr[WORD_W-1];
      sr   <= {sr[WORD_W-2:0], 1'b0};
    end
  end

  a_r10_release_low: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !miso);
  a_r4_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn_s && !sclk_fall) |=> $stable(miso));
endmodule

// File: rtl/spi_regbridge_slave.sv
module spi_regbridge_slave
  import spi_rb_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned SYNC_N = DEF_SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic [WORD_W-1:0] bus_rdata
);
  logic sclk_rise, sclk_fall, csn_s, mosi_s, data_phase;

  spi_rb_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sclk_i(spi_sclk), .csn_i(spi_csn), .mosi_i(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .csn_s(csn_s), .mosi_s(mosi_s)
  );

  spi_rb_frame #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise), .csn_s(csn_s), .mosi_s(mosi_s),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .data_phase(data_phase)
  );

  spi_rb_tx #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .csn_s(csn_s), .sclk_fall(sclk_fall), .data_phase(data_phase),
    .load(bus_rd), .rdata(bus_rdata), .miso(spi_miso)
  );
endmodule

// File: tb/spi_regbridge_slave_test.sv
module spi_regbridge_slave_test;
  localparam int AW = 4;
  localparam int W  = 32;
  localparam int H  = 6;   // clk cycles per SCLK phase
  localparam int NREG = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso;
  logic [AW-1:0] bus_addr;
  logic [W-1:0]  bus_wdata, bus_rdata;
  logic bus_wr, bus_rd;

  always #4 clk = ~clk;

  spi_regbridge_slave #(.WORD_W(W), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi), .spi_miso(miso),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  logic [W-1:0] model [NREG];
  logic [W-1:0] expv  [NREG];
  int wr_cnt = 0, rd_cnt = 0;
  logic [AW-1:0] last_wr_addr = '0, last_rd_addr = '0;
  logic [W-1:0]  last_wdata = '0;
  int total = 0, bad = 0;

  assign bus_rdata = model[bus_addr];

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_wr) begin
        wr_cnt++;
        last_wr_addr = bus_addr;
        last_wdata = bus_wdata;
        if (bus_addr != '0) model[bus_addr] = bus_wdata;
      end
      if (bus_rd) begin
        rd_cnt++;
        last_rd_addr = bus_addr;
      end
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic frame(input logic [W-1:0] w0, input logic [W-1:0] w1,
                       input int nbits, output logic [63:0] rx);
    logic [63:0] tx;
    tx = {w0, w1};
    rx = '0;
    csn = 1'b0;
    clks(H);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      mosi = (i < 64) ? tx[63-i] : 1'b1;
      clks(H);
      rx = {rx[62:0], miso};
      sclk = 1'b1;
      clks(H);
    end
    sclk = 1'b0;
    clks(H);
    csn = 1'b1;
    mosi = 1'b0;
    clks(3*H);
  endtask

  initial begin
    logic [63:0] rx;
    int wc, rc;
    logic [W-1:0] v;
    for (int a = 0; a < NREG; a++) begin
      model[a] = '0;
      expv[a] = '0;
    end
    model[0] = 32'hDEADBEEF;
    expv[0]  = 32'hDEADBEEF;
    clks(5);
    rst_n = 1'b1;
    clks(3);
    chk("R1", "idle bus_wr", 64'(bus_wr), 64'd0);
    chk("R1", "idle bus_rd", 64'(bus_rd), 64'd0);
    chk("R1", "idle miso", 64'(miso), 64'd0);

    for (int a = 0; a < NREG; a++) begin
      v = {8'hC3, 8'(a), 16'(a * 16'h2B7 + 16'h1111)};
      wc = wr_cnt; rc = rd_cnt;
      frame(W'(a), v, 64, rx);
      chk("R2", "write count", 64'(wr_cnt), 64'(wc + 1));
      chk("R2", "write addr", 64'(last_wr_addr), 64'(a));
      chk("R2", "write data", 64'(last_wdata), 64'(v));
      chk("R5", "no read in write frame", 64'(rd_cnt), 64'(rc));
      chk("R10", "miso low in write frame", rx, 64'd0);
      if (a != 0) expv[a] = v;
    end

    for (int a = 0; a < NREG; a++) begin
      wc = wr_cnt; rc = rd_cnt;
      frame(32'h8000_0000 | W'(a), 32'hFFFF_FFFF, 64, rx);
      chk("R3", "read count", 64'(rd_cnt), 64'(rc + 1));
      chk("R3", "read addr", 64'(last_rd_addr), 64'(a));
      chk("R4", "read data on miso", 64'(rx[31:0]), 64'(expv[a]));
      chk("R10", "miso low in first word", 64'(rx[63:32]), 64'd0);
      chk("R5", "no write in read frame", 64'(wr_cnt), 64'(wc));
    end

    // R9: upper address bits ignored
    wc = wr_cnt;
    frame(32'h7FFF_FFF5, 32'h0BAD_F00D, 64, rx);
    expv[5] = 32'h0BAD_F00D;
    chk("R9", "write with high bits count", 64'(wr_cnt), 64'(wc + 1));
    chk("R9", "write with high bits addr", 64'(last_wr_addr), 64'd5);
    frame(32'hFFFF_FFF5, 32'hFFFF_FFFF, 64, rx);
    chk("R9", "read with high bits data", 64'(rx[31:0]), 64'(expv[5]));

    // R6: write aborted after 40 bits, then R7 fresh decode
    wc = wr_cnt;
    frame(32'h0000_0007, 32'h55AA_55AA, 40, rx);
    chk("R6", "abort at 40 bits no write", 64'(wr_cnt), 64'(wc));
    rc = rd_cnt;
    frame(32'h8000_0007, 32'hFFFF_FFFF, 64, rx);
    chk("R7", "frame after abort reads", 64'(rd_cnt), 64'(rc + 1));
    chk("R7", "frame after abort data", 64'(rx[31:0]), 64'(expv[7]));

    // R6: write aborted one bit short
    wc = wr_cnt;
    frame(32'h0000_0003, 32'h1357_9BDF, 63, rx);
    chk("R6", "abort at 63 bits no write", 64'(wr_cnt), 64'(wc));
    frame(32'h8000_0003, 32'hFFFF_FFFF, 64, rx);
    chk("R6", "aborted write left reg", 64'(rx[31:0]), 64'(expv[3]));

    // R6: read aborted before first word ends
    rc = rd_cnt;
    frame(32'h8000_0002, 32'hFFFF_FFFF, 20, rx);
    chk("R6", "abort at 20 bits no read", 64'(rd_cnt), 64'(rc));

    // R8: overlong frames
    wc = wr_cnt;
    frame(32'h0000_0009, 32'hA0B1_C2D3, 70, rx);
    expv[9] = 32'hA0B1_C2D3;
    chk("R8", "overlong write one strobe", 64'(wr_cnt), 64'(wc + 1));
    chk("R8", "overlong write data", 64'(last_wdata), 64'hA0B1_C2D3);
    rc = rd_cnt; wc = wr_cnt;
    frame(32'h8000_0009, 32'hFFFF_FFFF, 72, rx);
    chk("R8", "overlong read one strobe", 64'(rd_cnt), 64'(rc + 1));
    chk("R8", "overlong read no write", 64'(wr_cnt), 64'(wc));

    chk("R1", "idle miso at end", 64'(miso), 64'd0);
    chk("R1", "idle strobes at end", 64'({bus_wr, bus_rd}), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule